// File: doc/BRIEF.md
# Variable-Block Carry-Skip Adder

This block adds two 32-bit unsigned operands and a carry-in and returns a 32-bit sum and a carry-out. It has no clock or state. Inside, the operand width is cut into ripple groups. Each group ripples its carry one bit at a time to form its own sum bits. A bypass multiplexer on each group hands the group's incoming carry straight to the next group when every bit of that group propagates. This shortens the worst carry path without adding full lookahead logic.

The default split uses unequal groups. The groups are short at both ends and longest in the middle, so a carry that starts or ends near an edge spends little time rippling. A parameter switches the block to a uniform split of equal groups, which gives a baseline for comparison. One skip-select bit per group is brought out so that a test can observe which bypasses are active.

Top module: `vbsk_adder`

## Requirements
- R1: For every input, `{c_out, sum_o}` read as a 33-bit unsigned number equals `a_in + b_in + c_in`.
- R2: With `SKIP_BLK = 0`, the word is cut from bit 0 upward into nine groups of 1, 3, 4, 5, 6, 5, 4, 3 and 1 bits. These start at bits 0, 1, 4, 8, 13, 19, 24, 28 and 31. `skip_o[k]` is 1 exactly when `a_in` and `b_in` differ in every bit of group k.
- R3: When `b_in == ~a_in`, every bit propagates. In that case `sum_o` is all ones when `c_in` is 0 and all zeros when `c_in` is 1, `c_out` equals `c_in`, and every `skip_o` bit is 1.
- R4: When `a_in` is the bit mask of a single group k and `b_in` is 0, `skip_o` has only bit k set and `sum_o` equals the mask plus `c_in`.
- R5: With both operands zero, `sum_o` equals `c_in`, `c_out` is 0 and `skip_o` is all zeros.
- R6: With `a_in = 32'hFFFF_FFFF`, `b_in = 1` and `c_in = 0`, `sum_o` is 0, `c_out` is 1, and `skip_o` has every group set except group 0.
- R7: With `SKIP_BLK = 4`, the block uses eight groups of 4 bits. `skip_o[k]` is 1 exactly when the operands differ in all of bits 4k to 4k+3, and R1 still holds.
- R8: The outputs depend only on the present inputs. They reach their new values within the same time step, with no clock edge needed.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a_in | input | 32 | First operand |
| b_in | input | 32 | Second operand |
| c_in | input | 1 | Carry into bit 0 |
| sum_o | output | 32 | Sum bits |
| c_out | output | 1 | Carry leaving the top group |
| skip_o | output | 9 (default), 32/SKIP_BLK otherwise | Bypass select of each group, bit 0 = lowest group |

## Verification
The assertions evaluate only when all operand and carry-in bits are known 0 or 1; any unknown input bit suspends them. The bench holds every input at a defined value from time zero, so the assertions always evaluate. The bench changes all three inputs together on the falling clock edge and reads the results two nanoseconds later, after the combinational outputs have settled. The sweeps use exhaustive low-order operand values under a long propagating run, single-group masks, and complementary operands. These keep each group's bypass and ripple paths active without relying on any input ordering.

// File: rtl/vbsk_pkg.sv
package vbsk_pkg;

    localparam int ADD_W      = 32;
    localparam int VAR_GROUPS = 9;

    typedef struct packed {
        logic p;
        logic g;
    } pg_t;

    typedef struct packed {
        logic             carry;
        logic [ADD_W-1:0] sum;
    } add_res_t;

    // number of groups: variable profile when blk == 0, else uniform split
    function automatic int group_count(input int blk);
        return (blk == 0) ? VAR_GROUPS : ADD_W / blk;
    endfunction

    // width of group k, counted from the least significant end
    function automatic int group_len(input int blk, input int k);
        if (blk != 0) return blk;
        case (k)
            0:       return 1;
            1:       return 3;
            2:       return 4;
            3:       return 5;
            4:       return 6;
            5:       return 5;
            6:       return 4;
            7:       return 3;
            default: return 1;
        endcase
    endfunction

    // lowest bit index of group k
    function automatic int group_base(input int blk, input int k);
        int acc;
        acc = 0;
        for (int i = 0; i < k; i++) acc += group_len(blk, i);
        return acc;
    endfunction

endpackage

// File: rtl/vbsk_bit_cell.sv
module vbsk_bit_cell
    import vbsk_pkg::*;
(
    input  logic a,
    input  logic b,
    input  logic ci,
    output logic s,
    output logic p,
    output logic co
);
    pg_t pg;

    assign pg.p = a ^ b;
    assign pg.g = a & b;
    assign s    = pg.p ^ ci;
    // mux-style carry: pass when propagating, else both operands agree (= g)
    assign co   = pg.p ? ci : pg.g;
    assign p    = pg.p;
endmodule

// File: rtl/vbsk_group.sv
module vbsk_group #(
    parameter int LEN = 4
) (
    input  logic [LEN-1:0] a,
    input  logic [LEN-1:0] b,
    input  logic           ci,
    output logic [LEN-1:0] s,
    output logic           co,
    output logic           skip
);
    logic [LEN:0]   rc;
    logic [LEN-1:0] pv;

    assign rc[0] = ci;

    for (genvar i = 0; i < LEN; i++) begin : g_bit
        vbsk_bit_cell u_cell (
            .a  (a[i]),
            .b  (b[i]),
            .ci (rc[i]),
            .s  (s[i]),
            .p  (pv[i]),
            .co (rc[i+1])
        );
    end

    // bypass: whole group propagates, so forward the incoming carry
    assign skip = &pv;
    assign co   = skip ? ci : rc[LEN];
endmodule

// File: rtl/vbsk_adder.sv
module vbsk_adder
    import vbsk_pkg::*;
#(
    parameter int SKIP_BLK = 0
) (
    input  logic [ADD_W-1:0]                 a_in,
    input  logic [ADD_W-1:0]                 b_in,
    input  logic                             c_in,
    output logic [ADD_W-1:0]                 sum_o,
    output logic                             c_out,
    output logic [group_count(SKIP_BLK)-1:0] skip_o
);
    localparam int NG = group_count(SKIP_BLK);

    logic [NG:0] gc;
    add_res_t    res;

    assign gc[0] = c_in;

    for (genvar k = 0; k < NG; k++) begin : g_grp
        localparam int LEN  = group_len(SKIP_BLK, k);
        localparam int BASE = group_base(SKIP_BLK, k);

        vbsk_group #(.LEN(LEN)) u_grp (
            .a    (a_in[BASE +: LEN]),
            .b    (b_in[BASE +: LEN]),
            .ci   (gc[k]),
            .s    (res.sum[BASE +: LEN]),
            .co   (gc[k+1]),
            .skip (skip_o[k])
        );
    end

    assign res.carry = gc[NG];
    assign sum_o     = res.sum;
    assign c_out     = res.carry;
endmodule

// File: rtl/vbsk_adder_chk.sv
module vbsk_adder_chk
    import vbsk_pkg::*;
#(
    parameter int SKIP_BLK = 0
) (
    input logic [ADD_W-1:0]                 a,
    input logic [ADD_W-1:0]                 b,
    input logic                             cin,
    input logic [ADD_W-1:0]                 sum,
    input logic                             cout,
    input logic [group_count(SKIP_BLK)-1:0] skip
);
    localparam int NG = group_count(SKIP_BLK);

    logic known;
    assign known = !$isunknown({a, b, cin});

    // R1: arithmetic result matches the exact 33-bit sum
    always_comb begin
        if (known) begin
            a_r1_sum_exact: assert ({cout, sum} ==
                ({1'b0, a} + {1'b0, b} + {{ADD_W{1'b0}}, cin}))
                else $error("R1 sum mismatch");
        end
    end

    // R2 / R7: each skip bit tracks whole-group propagation at the ports
    for (genvar k = 0; k < NG; k++) begin : g_skip
        localparam int LEN  = group_len(SKIP_BLK, k);
        localparam int BASE = group_base(SKIP_BLK, k);
        logic [LEN-1:0] da, db;
        assign da = a[BASE +: LEN];
        assign db = b[BASE +: LEN];
        always_comb begin
            if (known) begin
                a_r2_skip_group: assert (skip[k] == (da == ~db))
                    else $error("R2 skip bit %0d wrong", k);
            end
        end
    end

    // R3: full propagation passes the carry-in straight through
    always_comb begin
        if (known && (b == ~a)) begin
            a_r3_full_prop: assert ((cout == cin) && (&skip) &&
                (sum == {ADD_W{~cin}}))
                else $error("R3 full propagate wrong");
        end
    end

    // R5: zero operands
    always_comb begin
        if (known && (a == '0) && (b == '0)) begin
            a_r5_zero_ops: assert ((cout == 1'b0) && (skip == '0) &&
                (sum == {{(ADD_W-1){1'b0}}, cin}))
                else $error("R5 zero operands wrong");
        end
    end
endmodule

bind vbsk_adder vbsk_adder_chk #(.SKIP_BLK(SKIP_BLK)) u_chk (
    .a    (a_in),
    .b    (b_in),
    .cin  (c_in),
    .sum  (sum_o),
    .cout (c_out),
    .skip (skip_o)
);

// File: tb/vbsk_adder_test.sv
module vbsk_adder_test;

    logic clk = 1'b0;
    always #4 clk = ~clk;   // 125 MHz

    logic [31:0] a = '0, b = '0;
    logic        ci = 1'b0;
    logic [31:0] sv, su;
    logic        cv, cu;
    logic [8:0]  kv;
    logic [7:0]  ku;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    vbsk_adder uut (
        .a_in (a), .b_in (b), .c_in (ci),
        .sum_o (sv), .c_out (cv), .skip_o (kv)
    );

    vbsk_adder #(.SKIP_BLK(4)) uut_uni (
        .a_in (a), .b_in (b), .c_in (ci),
        .sum_o (su), .c_out (cu), .skip_o (ku)
    );

    // group widths of the default split, lowest group first (R2)
    function automatic int vlen(input int k);
        int t [9] = '{1, 3, 4, 5, 6, 5, 4, 3, 1};
        return t[k];
    endfunction

    function automatic logic [31:0] vmask(input int k);
        int base = 0;
        for (int i = 0; i < k; i++) base += vlen(i);
        return ((32'h1 << vlen(k)) - 32'h1) << base;
    endfunction

    function automatic logic [8:0] exp_kv(input logic [31:0] x, input logic [31:0] y);
        logic [8:0] r;
        for (int k = 0; k < 9; k++) r[k] = (((x ^ y) & vmask(k)) == vmask(k));
        return r;
    endfunction

    function automatic logic [7:0] exp_ku(input logic [31:0] x, input logic [31:0] y);
        logic [7:0] r;
        logic [31:0] p;
        p = x ^ y;
        for (int k = 0; k < 8; k++) r[k] = (p[4*k +: 4] == 4'hF);
        return r;
    endfunction

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic apply(input logic [31:0] va, input logic [31:0] vb, input logic vc);
        logic [32:0] ref_sum;
        @(negedge clk);
        a = va; b = vb; ci = vc;
        #2;
        ref_sum = {1'b0, va} + {1'b0, vb} + {32'b0, vc};
        check("R1", {31'b0, cv, sv}, {31'b0, ref_sum});
        check("R2", {55'b0, kv}, {55'b0, exp_kv(va, vb)});
        check("R7", {31'b0, cu, su}, {31'b0, ref_sum});
        check("R7", {56'b0, ku}, {56'b0, exp_ku(va, vb)});
    endtask

    initial begin
        #(8 * 190000);
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        // R5: zero plus zero, both carry-in values
        for (int c = 0; c < 2; c++) begin
            apply('0, '0, c[0]);
            check("R5", {31'b0, cv, sv}, {32'b0, 31'b0, c[0]});
            check("R5", {55'b0, kv}, 64'd0);
        end

        // R6: all ones plus one
        apply(32'hFFFF_FFFF, 32'h1, 1'b0);
        check("R6", {31'b0, cv, sv}, {31'b0, 1'b1, 32'h0});
        check("R6", {55'b0, kv}, {55'b0, 9'h1FE});

        // R3: complementary operands, carry passes through
        for (int c = 0; c < 2; c++) begin
            for (int i = 0; i < 8; i++) begin
                logic [31:0] x;
                x = 32'h1357_9BDF * (i + 1);
                apply(x, ~x, c[0]);
                check("R3", {31'b0, cv, sv}, {31'b0, c[0], {32{~c[0]}}});
                check("R3", {55'b0, kv}, {55'b0, 9'h1FF});
            end
        end

        // R4: exactly one group propagates
        for (int k = 0; k < 9; k++) begin
            for (int c = 0; c < 2; c++) begin
                apply(vmask(k), 32'h0, c[0]);
                check("R4", {55'b0, kv}, {55'b0, 9'h1 << k});
                check("R4", {32'b0, sv}, {32'b0, vmask(k) + {31'b0, c[0]}});
            end
        end

        // R8: outputs follow inputs with clock held low
        @(negedge clk);
        a = 32'h0000_00FF; b = 32'h0000_0001; ci = 1'b0;
        #1;
        check("R8", {31'b0, cv, sv}, {31'b0, 1'b0, 32'h0000_0100});

        // R1: exhaustive low 7 bits under a long propagating upper run
        for (int ia = 0; ia < 128; ia++) begin
            for (int ib = 0; ib < 128; ib++) begin
                apply({25'h1FF_FFFF, ia[6:0]}, {25'h0, ib[6:0]}, ia[0] ^ ib[1]);
            end
        end

        // R1 / R7: pseudo-random operands
        for (int n = 0; n < 3000; n++) begin
            apply($urandom, $urandom, n[0]);
        end

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule